// File: doc/BRIEF.md
# Pixel Clock Divider Search

This block picks the settings of a clock generator that drives a display: a PLL multiplier applied to a 3 MHz reference step, an integer post-divider, and a flag that selects a doubled path with an effective 6 MHz step. A target pixel clock in kHz arrives with a start strobe. The block then walks the candidate settings one after another and keeps the candidate whose output is closest to the target without going over it.

Each candidate needs two integer divisions. Both run on a single shared restoring divider, one quotient bit per cycle. Every run visits the same fixed set of candidates, so the result always arrives after the same number of cycles. The chosen multiplier, divider, doubling flag and achieved frequency stay on the outputs until the next run completes. If no candidate is acceptable, a no-solution flag is raised instead.

Top module: `pixclk_search`

## Requirements
- R1: After reset, `busy`, `done`, `no_fit` and `dbl` are 0, and `pll_n`, `post_m` and `achieved_khz` are 0.
- R2: A `start` pulse while idle captures `target_khz`. `busy` is 1 from the next cycle. After exactly 23 × 49 = 1127 busy cycles, `done` is 1 for one cycle, `busy` is 0 in that cycle, and the results are valid from that cycle.
- R3: For each divider value m, taken in the order 15, 14, …, 1, the single-rate candidate is n = floor(m·f/3000). It is valid only if 9 ≤ n ≤ 127, and its achieved clock is floor(3000·n/m).
- R4: Only odd m values get a doubled candidate, evaluated right after that m's single-rate candidate. Its n = floor(m·f/6000) with the same n range, and its achieved clock is floor(6000·n/m). Choosing it drives `dbl` = 1, and `post_m` is then always odd.
- R5: The error is target minus achieved. The best starts at error 0x0FFFFFFF. A valid candidate replaces the best only if its error is strictly smaller, so on a tie the earlier candidate (larger m, single before doubled) is kept. For example, a target of 27000 yields n = 126, m = 14, `dbl` = 0.
- R6: When a solution exists, `achieved_khz` never exceeds the captured target.
- R7: When no candidate is valid, `no_fit` = 1 and `pll_n`, `post_m`, `dbl` and `achieved_khz` are all 0. Otherwise `no_fit` = 0 and 9 ≤ `pll_n` ≤ 127, 1 ≤ `post_m` ≤ 15.
- R8: A `start` pulse while busy is ignored: neither that run's result nor its completion time changes. Result outputs hold their values from one completion to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; taken only while idle |
| target_khz | input | 20 | Target pixel clock in kHz, unsigned |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| pll_n | output | 7 | Chosen multiplier; the PLL runs at pll_n × 3 MHz |
| post_m | output | 4 | Chosen post-divider |
| dbl | output | 1 | 1 when the doubled (6 MHz step) path is chosen |
| achieved_khz | output | 20 | Resulting pixel clock in kHz |
| no_fit | output | 1 | No valid candidate was found |

## Verification
The only timing that matters is the fixed latency: `done` rises exactly 1127 clock edges after the edge that samples `start`. Every result and the drop of `busy` are due in that same cycle. Each directed task counts edges from the accepting edge and samples the outputs on the falling edge after each one. A check fails if `done` appears a cycle early or late. The held-output and ignored-start checks sample the outputs several cycles after completion, and in the middle of a run, before any new completion could occur.

// File: rtl/pixclk_search.sv
module pixclk_search #(
  parameter int FW    = 20,
  parameter int NW    = 7,
  parameter int MW    = 4,
  parameter int M_MAX = 15,
  parameter int N_MIN = 9,
  parameter int N_MAX = 127,
  parameter int STEP  = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] target_khz,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] pll_n,
  output logic [MW-1:0] post_m,
  output logic          dbl,
  output logic [FW-1:0] achieved_khz,
  output logic          no_fit
);
  localparam int NUMW = FW + MW;
  localparam int DVW  = $clog2(2 * STEP + 1);
  localparam int CW   = $clog2(NUMW + 1);
  localparam int EW   = 28;
  localparam logic [EW-1:0] ERR_INIT = 28'h0FFFFFFF;

  typedef enum logic [1:0] {S_IDLE, S_DIV1, S_DIV2, S_EVAL} st_t;
  st_t st;

  logic [FW-1:0]   tgt_r, ach_r;
  logic [MW-1:0]   m_r;
  logic            ph_dbl;
  logic [CW-1:0]   cnt;
  logic [NUMW-1:0] num_r, quo_r;
  logic [DVW-1:0]  rem_r;
  logic [NW-1:0]   cand_n;
  logic            cand_ok;
  logic [EW-1:0]   best_err;
  logic [NW-1:0]   best_n;
  logic [MW-1:0]   best_m;
  logic            best_dbl;
  logic [FW-1:0]   best_ach;

  logic [DVW-1:0]  divisor;
  logic [DVW:0]    rem_sh;
  logic            qbit;
  logic [NUMW-1:0] q_next;
  logic [DVW-1:0]  rem_next;
  logic [DVW-1:0]  step_cur;
  logic            in_rng;
  logic [EW-1:0]   err;
  logic            take;
  logic            next_dbl, last;
  logic [NW-1:0]   u_n;
  logic [MW-1:0]   u_m;
  logic            u_dbl;
  logic [FW-1:0]   u_ach;

  assign busy     = (st != S_IDLE);
  assign step_cur = ph_dbl ? DVW'(2 * STEP) : DVW'(STEP);
  assign divisor  = (st == S_DIV1) ? step_cur : DVW'(m_r);
  assign rem_sh   = {rem_r, num_r[NUMW-1]};
  assign qbit     = (rem_sh >= {1'b0, divisor});
  assign rem_next = qbit ? DVW'(rem_sh - {1'b0, divisor}) : rem_sh[DVW-1:0];
  assign q_next   = {quo_r[NUMW-2:0], qbit};
  assign in_rng   = (q_next >= NUMW'(N_MIN)) && (q_next <= NUMW'(N_MAX));

  assign err      = EW'(tgt_r) - EW'(ach_r);
  assign take     = cand_ok && (err < best_err);
  assign u_n      = take ? cand_n : best_n;
  assign u_m      = take ? m_r    : best_m;
  assign u_dbl    = take ? ph_dbl : best_dbl;
  assign u_ach    = take ? ach_r  : best_ach;
  assign next_dbl = !ph_dbl && m_r[0];
  assign last     = !next_dbl && (m_r == MW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      done         <= 1'b0;
      tgt_r        <= '0;
      ach_r        <= '0;
      m_r          <= '0;
      ph_dbl       <= 1'b0;
      cnt          <= '0;
      num_r        <= '0;
      quo_r        <= '0;
      rem_r        <= '0;
      cand_n       <= '0;
      cand_ok      <= 1'b0;
      best_err     <= ERR_INIT;
      best_n       <= '0;
      best_m       <= '0;
      best_dbl     <= 1'b0;
      best_ach     <= '0;
      pll_n        <= '0;
      post_m       <= '0;
      dbl          <= 1'b0;
      achieved_khz <= '0;
      no_fit       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tgt_r    <= target_khz;
          m_r      <= MW'(M_MAX);
          ph_dbl   <= 1'b0;
          best_err <= ERR_INIT;
          best_n   <= '0;
          best_m   <= '0;
          best_dbl <= 1'b0;
          best_ach <= '0;
          num_r    <= NUMW'(MW'(M_MAX)) * NUMW'(target_khz);
          quo_r    <= '0;
          rem_r    <= '0;
          cnt      <= '0;
          st       <= S_DIV1;
        end
        S_DIV1: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NUMW - 1)) begin
            cand_ok <= in_rng;
            cand_n  <= q_next[NW-1:0];
            num_r   <= NUMW'(step_cur) * NUMW'(q_next[NW-1:0]);
            quo_r   <= '0;
            rem_r   <= '0;
            cnt     <= '0;
            st      <= S_DIV2;
          end else begin
            num_r <= num_r << 1;
            quo_r <= q_next;
            rem_r <= rem_next;
          end
        end
        S_DIV2: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NUMW - 1)) begin
            ach_r <= q_next[FW-1:0];
            st    <= S_EVAL;
          end else begin
            num_r <= num_r << 1;
            quo_r <= q_next;
            rem_r <= rem_next;
          end
        end
        S_EVAL: begin
          if (take) best_err <= err;
          best_n   <= u_n;
          best_m   <= u_m;
          best_dbl <= u_dbl;
          best_ach <= u_ach;
          if (last) begin
            pll_n        <= u_n;
            post_m       <= u_m;
            dbl          <= u_dbl;
            achieved_khz <= u_ach;
            no_fit       <= (u_m == '0);
            done         <= 1'b1;
            st           <= S_IDLE;
          end else begin
            ph_dbl <= next_dbl;
            if (!next_dbl) m_r <= m_r - 1'b1;
            num_r <= NUMW'(next_dbl ? m_r : MW'(m_r - 1'b1)) * NUMW'(tgt_r);
            quo_r <= '0;
            rem_r <= '0;
            cnt   <= '0;
            st    <= S_DIV1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pixclk_search_chk #(
  parameter int FW = 20,
  parameter int NW = 7,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [FW-1:0] target_khz,
  input logic          busy,
  input logic          done,
  input logic [NW-1:0] pll_n,
  input logic [MW-1:0] post_m,
  input logic          dbl,
  input logic [FW-1:0] achieved_khz,
  input logic          no_fit
);
  logic [FW-1:0] tgt_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) tgt_seen <= '0;
    else if (start && !busy) tgt_seen <= target_khz;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_dbl_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dbl) |-> post_m[0]);
  assert_not_over_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_fit) |-> (achieved_khz <= tgt_seen));
  assert_nofit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_fit) |-> (pll_n == '0 && post_m == '0 && !dbl && achieved_khz == '0));
  assert_fit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_fit) |-> (pll_n >= 7'd9 && pll_n <= 7'd127 && post_m != '0));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(rst_n)) |-> ($stable(pll_n) && $stable(post_m) && $stable(achieved_khz) && $stable(no_fit)));
endmodule

bind pixclk_search pixclk_search_chk #(.FW(FW), .NW(NW), .MW(MW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
  .busy(busy), .done(done), .pll_n(pll_n), .post_m(post_m), .dbl(dbl),
  .achieved_khz(achieved_khz), .no_fit(no_fit)
);

// File: tb/pixclk_search_tb.sv
module pixclk_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 23 * 49;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [19:0] target_khz = '0;
  logic busy, done, dbl, no_fit;
  logic [6:0] pll_n;
  logic [3:0] post_m;
  logic [19:0] achieved_khz;

  int n_tests = 0;
  int n_fail = 0;
  int cyc_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixclk_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .busy(busy), .done(done), .pll_n(pll_n), .post_m(post_m), .dbl(dbl),
    .achieved_khz(achieved_khz), .no_fit(no_fit)
  );

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, got %0d cycles, expected < 150000", cyc_total);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input int f, output int en, output int em, output int ed, output int ea, output int enf);
    int be = 32'h0FFFFFFF;
    en = 0; em = 0; ed = 0; ea = 0;
    for (int m = 15; m >= 1; m--) begin
      for (int d = 0; d < 2; d++) begin
        int step, n, a;
        if (d == 1 && (m % 2 == 0)) continue;
        step = d ? 6000 : 3000;
        n = (m * f) / step;
        if (n >= 9 && n <= 127) begin
          a = (step * n) / m;
          if (f - a < be) begin
            be = f - a; en = n; em = m; ed = d; ea = a;
          end
        end
      end
    end
    enf = (em == 0);
  endtask

  task automatic kick(input int f);
    @(negedge clk);
    start = 1'b1;
    target_khz = 20'(f);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    do begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end while (!done && k < LAT + 50);
  endtask

  task automatic run_case(input int f, input string req);
    int k, en, em, ed, ea, enf;
    model(f, en, em, ed, ea, enf);
    kick(f);
    chk("R2", "busy after start", busy, 1);
    wait_done(k);
    chk("R2", "latency", k, LAT);
    chk("R2", "busy at done", busy, 0);
    chk(req, "pll_n", pll_n, en);
    chk(req, "post_m", post_m, em);
    chk(req, "dbl", dbl, ed);
    chk(req, "achieved", achieved_khz, ea);
    chk("R7", "no_fit", no_fit, enf);
    if (!enf) chk("R6", "not over target", achieved_khz <= 20'(f), 1);
    @(negedge clk);
    chk("R2", "done single cycle", done, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "outputs", {pll_n, post_m, dbl, achieved_khz, no_fit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_tie;
    run_case(27000, "R5");
    chk("R5", "tie keeps m=14", post_m, 14);
    chk("R5", "tie n=126", pll_n, 126);
    chk("R5", "tie dbl=0", dbl, 0);
  endtask

  task automatic t_doubled;
    run_case(762000, "R4");
    chk("R4", "doubled chosen", dbl, 1);
    chk("R4", "doubled m=1", post_m, 1);
    chk("R4", "doubled n=127", pll_n, 127);
  endtask

  task automatic t_nofit;
    run_case(100, "R7");
    chk("R7", "low no_fit", no_fit, 1);
    run_case(1048575, "R7");
    chk("R7", "high no_fit", no_fit, 1);
    chk("R7", "high zero n", pll_n, 0);
  endtask

  task automatic t_busy_ignore;
    int k, en, em, ed, ea, enf, p_n;
    run_case(65000, "R3");
    p_n = pll_n;
    model(148500, en, em, ed, ea, enf);
    kick(148500);
    repeat (100) @(negedge clk);
    chk("R8", "held during run", pll_n, p_n);
    start = 1'b1;
    target_khz = 20'd25175;
    @(negedge clk);
    start = 1'b0;
    k = 101;
    do begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end while (!done && k < LAT + 50);
    chk("R8", "latency unchanged", k, LAT);
    chk("R8", "pll_n of first target", pll_n, en);
    chk("R8", "post_m of first target", post_m, em);
    chk("R8", "achieved of first target", achieved_khz, ea);
    repeat (5) @(negedge clk);
    chk("R8", "held after done", achieved_khz, ea);
    chk("R8", "idle after done", busy, 0);
  endtask

  initial begin
    t_reset();
    run_case(65000, "R3");
    run_case(25175, "R3");
    run_case(148500, "R3");
    run_case(300000, "R4");
    t_tie();
    t_doubled();
    t_nofit();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule